// File: doc/BRIEF.md
# Byte-Serial Counter Host Port

This block is the host-facing register port of one counter channel. The host sees two byte-wide locations, chosen by a single select line: a data location and a control location. Writes to the control location are commands. The top three bits of a command pick a target. The remaining bits are either a reset/transfer action or a new value for one of three configuration registers: mode, I/O control or index control. Reads from the control location return a byte of status flags from the counting logic.

Wide values move through the data location one byte at a time, least significant byte first, under a shared byte pointer. Data writes fill a 24-bit preset register. Data reads drain a 24-bit output latch. A command resets the pointer. Separate encoded commands copy the preset into the count, copy the count into the latch, or copy the preset's low byte into the input-filter prescaler. The count can only be changed through the preset. The counting logic sits outside this block: it supplies the live count and the status bits, and it receives the preset, the strobes and the configuration.

Top module: `cnt_host_port`

## Requirements
- R1: After a synchronous reset, `bus_rdata_o`, `preset_o`, `prescaler_o`, `mode_cfg_o`, `idx_cfg_o` and `irq_sel_o` are 0, all four strobes are low, `cnt_en_o` is 0, `idx_preset_en_o` is 0 (the raw I/O control register resets to 0b00010), and the byte pointer is at byte 0.
- R2: A control write uses bits 7:5 to pick the target: 000 reset/transfer action, 001 mode register, 010 I/O control register, 011 index register. Bits 4:0 are the payload. Codes 100 to 111 change no output, strobe, pointer or register.
- R3: I/O control payload decoding: bit 0 drives `cnt_en_o`; bit 1 is an active-low preset-on-index enable, brought out inverted on `idx_preset_en_o`; bits 4:3 drive `irq_sel_o`.
- R4: Each data write stores its byte into the preset at the byte pointer, starting with the least significant byte, and advances the pointer. After byte 2 the pointer wraps to byte 0.
- R5: In a reset/transfer action, payload bit 0 returns the byte pointer to byte 0.
- R6: Payload bits 2:1 form one field. 01 gives a one-cycle `cnt_clear_o`, 10 a one-cycle `flags_clear_o`, and 11 a one-cycle `error_clear_o` only. At most one of these strobes is high in any cycle.
- R7: Payload bits 4:3 = 01 give a one-cycle `cnt_load_o` in the cycle after the command, while `preset_o` holds the value to load.
- R8: Payload bits 4:3 = 10 capture `cnt_value_i` into the output latch at the command's clock edge. Data reads then return the latch byte at the pointer and advance it, with the same wrap. The latch keeps its value until the next capture, whatever the count does.
- R9: Payload bits 4:3 = 11 copy preset bits 7:0 into `prescaler_o`. In the combined code 0x19, the same command also resets the pointer. `prescaler_o` changes only this way.
- R10: A control read returns {0, index, up, error, sign, compare, carry, borrow} (bit 7 down to bit 0). It does not move the byte pointer.
- R11: Read data appears on `bus_rdata_o` in the cycle after the read strobe and holds until the next read. A strobe with both write and read high is served as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Host write strobe, one cycle per access |
| bus_rd_i | input | 1 | Host read strobe, one cycle per access |
| bus_ctl_i | input | 1 | 1 selects the control/status location, 0 the data location |
| bus_wdata_i | input | 8 | Host write byte |
| bus_rdata_o | output | 8 | Registered host read byte |
| cnt_value_i | input | 24 | Live count from the counting logic |
| st_borrow_i | input | 1 | Borrow toggle status |
| st_carry_i | input | 1 | Carry toggle status |
| st_compare_i | input | 1 | Compare toggle status |
| st_sign_i | input | 1 | Sign status |
| st_error_i | input | 1 | Input noise error status |
| st_up_i | input | 1 | Count direction, 1 = up |
| st_index_i | input | 1 | Index input level |
| preset_o | output | 24 | Preset register |
| prescaler_o | output | 8 | Input filter prescaler |
| cnt_load_o | output | 1 | One-cycle strobe: load preset into count |
| cnt_clear_o | output | 1 | One-cycle strobe: clear count |
| flags_clear_o | output | 1 | One-cycle strobe: clear borrow/carry/compare/sign |
| error_clear_o | output | 1 | One-cycle strobe: clear error flag |
| mode_cfg_o | output | 5 | Mode register payload |
| cnt_en_o | output | 1 | Count input enable |
| idx_preset_en_o | output | 1 | Preset on index enabled (active high) |
| irq_sel_o | output | 2 | Interrupt trigger select |
| idx_cfg_o | output | 5 | Index register payload |

## Verification
The bound checker watches, on every cycle, the properties that depend only on the bus strobes of the previous cycle. Every strobe must trace back to its own command code. The clear strobes must be mutually exclusive. Ignored target codes must leave the configuration untouched, and the prescaler and preset may change only after their own accesses. A control read must return the status byte, and read data must hold between reads. The byte pointer is hidden, so only the bench's scenarios can show least-significant-first ordering, wrap from byte 2 to byte 0, pointer reset by command, status reads that leave the pointer alone, and a latch that stays fixed while the count moves during a three-byte read. The bench covers these with a behavioural model compared each cycle and with a stretch of random traffic.

// File: rtl/cnt_host_pkg.sv
`timescale 1ns/1ps
package cnt_host_pkg;

  localparam logic [2:0] TGT_ACTION = 3'b000;
  localparam logic [2:0] TGT_MODE   = 3'b001;
  localparam logic [2:0] TGT_IOCTL  = 3'b010;
  localparam logic [2:0] TGT_INDEX  = 3'b011;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_COUNT = 2'b01,
    CLR_FLAGS = 2'b10,
    CLR_ERROR = 2'b11
  } clr_e;

  typedef enum logic [1:0] {
    XFR_NONE  = 2'b00,
    XFR_LOAD  = 2'b01,
    XFR_LATCH = 2'b10,
    XFR_PSC   = 2'b11
  } xfr_e;

  typedef struct packed {
    logic ptr_rst;
    logic ptr_step;
    logic wr_byte;
    logic rd_byte;
    logic rd_stat;
    clr_e clr;
    xfr_e xfr;
    logic mode_we;
    logic ioc_we;
    logic idx_we;
  } ops_t;

endpackage

// File: rtl/cnt_host_decode.sv
`timescale 1ns/1ps
module cnt_host_decode
  import cnt_host_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          ctl_i,
  input  logic [BW-1:0] wdata_i,
  output ops_t          ops_o
);

  logic [2:0] tgt;
  assign tgt = wdata_i[BW-1 -: 3];

  always_comb begin
    ops_o = '0;
    if (wr_i) begin
      if (ctl_i) begin
        case (tgt)
          TGT_ACTION: begin
            ops_o.ptr_rst = wdata_i[0];
            ops_o.clr     = clr_e'(wdata_i[2:1]);
            ops_o.xfr     = xfr_e'(wdata_i[4:3]);
          end
          TGT_MODE:  ops_o.mode_we = 1'b1;
          TGT_IOCTL: ops_o.ioc_we  = 1'b1;
          TGT_INDEX: ops_o.idx_we  = 1'b1;
          default: ;
        endcase
      end else begin
        ops_o.wr_byte  = 1'b1;
        ops_o.ptr_step = 1'b1;
      end
    end else if (rd_i) begin
      if (ctl_i) begin
        ops_o.rd_stat = 1'b1;
      end else begin
        ops_o.rd_byte  = 1'b1;
        ops_o.ptr_step = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cnt_host_ptr.sv
`timescale 1ns/1ps
module cnt_host_ptr #(
  parameter int NBYTES = 3,
  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ptr_o <= '0;
    end else if (step_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end

endmodule

// File: rtl/cnt_host_bank.sv
`timescale 1ns/1ps
module cnt_host_bank #(
  parameter int BW     = 8,
  parameter int NBYTES = 3,
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int WORD_W = BW * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              wr_byte_i,
  input  logic [BW-1:0]     wdata_i,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] cnt_value_i,
  output logic [WORD_W-1:0] preset_o,
  output logic [BW-1:0]     latch_byte_o
);

  logic [NBYTES-1:0][BW-1:0] preset_q;
  logic [NBYTES-1:0][BW-1:0] latch_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        preset_q[g] <= '0;
      end else if (wr_byte_i && (ptr_i == PTR_W'(g))) begin
        preset_q[g] <= wdata_i;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        latch_q[g] <= '0;
      end else if (cap_i) begin
        latch_q[g] <= cnt_value_i[g*BW +: BW];
      end
    end
  end

  always_comb begin
    latch_byte_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (ptr_i == PTR_W'(i)) latch_byte_o = latch_q[i];
    end
  end

  assign preset_o = preset_q;

endmodule

// File: rtl/cnt_host_cfg.sv
`timescale 1ns/1ps
module cnt_host_cfg #(
  parameter int             W   = 5,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)       q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/cnt_host_port.sv
`timescale 1ns/1ps
module cnt_host_port
  import cnt_host_pkg::*;
#(
  parameter int                 BW      = 8,
  parameter int                 NBYTES  = 3,
  parameter int                 CFG_W   = 5,
  parameter logic [CFG_W-1:0]   IOC_RST = CFG_W'(5'b00010),
  localparam int                WORD_W  = BW * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_ctl_i,
  input  logic [BW-1:0]     bus_wdata_i,
  output logic [BW-1:0]     bus_rdata_o,
  input  logic [WORD_W-1:0] cnt_value_i,
  input  logic              st_borrow_i,
  input  logic              st_carry_i,
  input  logic              st_compare_i,
  input  logic              st_sign_i,
  input  logic              st_error_i,
  input  logic              st_up_i,
  input  logic              st_index_i,
  output logic [WORD_W-1:0] preset_o,
  output logic [BW-1:0]     prescaler_o,
  output logic              cnt_load_o,
  output logic              cnt_clear_o,
  output logic              flags_clear_o,
  output logic              error_clear_o,
  output logic [CFG_W-1:0]  mode_cfg_o,
  output logic              cnt_en_o,
  output logic              idx_preset_en_o,
  output logic [1:0]        irq_sel_o,
  output logic [CFG_W-1:0]  idx_cfg_o
);

  localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  ops_t             ops;
  logic [PTR_W-1:0] ptr;
  logic [BW-1:0]    latch_byte;
  logic [BW-1:0]    status_byte;
  logic [CFG_W-1:0] ioc_q;

  cnt_host_decode #(.BW(BW)) u_decode (
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .ctl_i   (bus_ctl_i),
    .wdata_i (bus_wdata_i),
    .ops_o   (ops)
  );

  cnt_host_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (ops.ptr_rst),
    .step_i (ops.ptr_step),
    .ptr_o  (ptr)
  );

  cnt_host_bank #(.BW(BW), .NBYTES(NBYTES)) u_bank (
    .clk          (clk),
    .rst          (rst),
    .ptr_i        (ptr),
    .wr_byte_i    (ops.wr_byte),
    .wdata_i      (bus_wdata_i),
    .cap_i        (ops.xfr == XFR_LATCH),
    .cnt_value_i  (cnt_value_i),
    .preset_o     (preset_o),
    .latch_byte_o (latch_byte)
  );

  cnt_host_cfg #(.W(CFG_W), .RST('0)) u_mode (
    .clk (clk), .rst (rst), .we_i (ops.mode_we),
    .d_i (bus_wdata_i[CFG_W-1:0]), .q_o (mode_cfg_o)
  );

  cnt_host_cfg #(.W(CFG_W), .RST(IOC_RST)) u_ioc (
    .clk (clk), .rst (rst), .we_i (ops.ioc_we),
    .d_i (bus_wdata_i[CFG_W-1:0]), .q_o (ioc_q)
  );

  cnt_host_cfg #(.W(CFG_W), .RST('0)) u_idx (
    .clk (clk), .rst (rst), .we_i (ops.idx_we),
    .d_i (bus_wdata_i[CFG_W-1:0]), .q_o (idx_cfg_o)
  );

  assign cnt_en_o        = ioc_q[0];
  assign idx_preset_en_o = ~ioc_q[1];
  assign irq_sel_o       = ioc_q[4:3];

  assign status_byte = BW'({1'b0, st_index_i, st_up_i, st_error_i,
                            st_sign_i, st_compare_i, st_carry_i, st_borrow_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_load_o    <= 1'b0;
      cnt_clear_o   <= 1'b0;
      flags_clear_o <= 1'b0;
      error_clear_o <= 1'b0;
    end else begin
      cnt_load_o    <= (ops.xfr == XFR_LOAD);
      cnt_clear_o   <= (ops.clr == CLR_COUNT);
      flags_clear_o <= (ops.clr == CLR_FLAGS);
      error_clear_o <= (ops.clr == CLR_ERROR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prescaler_o <= '0;
    end else if (ops.xfr == XFR_PSC) begin
      prescaler_o <= preset_o[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (ops.rd_stat) begin
      bus_rdata_o <= status_byte;
    end else if (ops.rd_byte) begin
      bus_rdata_o <= latch_byte;
    end
  end

endmodule

// File: rtl/cnt_host_port_chk.sv
`timescale 1ns/1ps
module cnt_host_port_chk #(
  parameter int BW     = 8,
  parameter int NBYTES = 3,
  parameter int CFG_W  = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr_i,
  input logic                 bus_rd_i,
  input logic                 bus_ctl_i,
  input logic [BW-1:0]        bus_wdata_i,
  input logic [BW-1:0]        bus_rdata_o,
  input logic                 st_borrow_i,
  input logic                 st_carry_i,
  input logic                 st_compare_i,
  input logic                 st_sign_i,
  input logic                 st_error_i,
  input logic                 st_up_i,
  input logic                 st_index_i,
  input logic [BW*NBYTES-1:0] preset_o,
  input logic [BW-1:0]        prescaler_o,
  input logic                 cnt_load_o,
  input logic                 cnt_clear_o,
  input logic                 flags_clear_o,
  input logic                 error_clear_o,
  input logic [CFG_W-1:0]     mode_cfg_o,
  input logic                 cnt_en_o,
  input logic [1:0]           irq_sel_o,
  input logic [CFG_W-1:0]     idx_cfg_o
);

  logic act_cmd;
  assign act_cmd = bus_wr_i && bus_ctl_i && (bus_wdata_i[BW-1 -: 3] == 3'b000);

  a_r6_clear_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cnt_clear_o, flags_clear_o, error_clear_o}));

  a_r6_clear_source: assert property (@(posedge clk) disable iff (rst)
    cnt_clear_o |-> $past(act_cmd && bus_wdata_i[2:1] == 2'b01));

  a_r7_load_source: assert property (@(posedge clk) disable iff (rst)
    cnt_load_o |-> $past(act_cmd && bus_wdata_i[4:3] == 2'b01));

  a_r9_psc_source: assert property (@(posedge clk) disable iff (rst)
    (prescaler_o != $past(prescaler_o)) |-> $past(act_cmd && bus_wdata_i[4:3] == 2'b11));

  a_r4_preset_source: assert property (@(posedge clk) disable iff (rst)
    (preset_o != $past(preset_o)) |-> $past(bus_wr_i && !bus_ctl_i));

  a_r2_ignored_target: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr_i && bus_ctl_i && bus_wdata_i[BW-1]) |->
      ($stable(mode_cfg_o) && $stable(idx_cfg_o) && $stable(irq_sel_o) &&
       $stable(cnt_en_o) && !cnt_load_o && !cnt_clear_o));

  a_r10_status_read: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd_i && !bus_wr_i && bus_ctl_i) |->
      (bus_rdata_o == $past(BW'({1'b0, st_index_i, st_up_i, st_error_i, st_sign_i,
                                 st_compare_i, st_carry_i, st_borrow_i}))));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_rd_i || bus_wr_i) |-> $stable(bus_rdata_o));

endmodule

bind cnt_host_port cnt_host_port_chk #(.BW(BW), .NBYTES(NBYTES), .CFG_W(CFG_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_ctl_i     (bus_ctl_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .st_borrow_i   (st_borrow_i),
  .st_carry_i    (st_carry_i),
  .st_compare_i  (st_compare_i),
  .st_sign_i     (st_sign_i),
  .st_error_i    (st_error_i),
  .st_up_i       (st_up_i),
  .st_index_i    (st_index_i),
  .preset_o      (preset_o),
  .prescaler_o   (prescaler_o),
  .cnt_load_o    (cnt_load_o),
  .cnt_clear_o   (cnt_clear_o),
  .flags_clear_o (flags_clear_o),
  .error_clear_o (error_clear_o),
  .mode_cfg_o    (mode_cfg_o),
  .cnt_en_o      (cnt_en_o),
  .irq_sel_o     (irq_sel_o),
  .idx_cfg_o     (idx_cfg_o)
);

// File: tb/cnt_host_port_tb_top.sv
`timescale 1ns/1ps
module cnt_host_port_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_ctl = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [23:0] cnt_value = 24'h0;
  logic        st_b = 0, st_c = 0, st_cmp = 0, st_s = 0, st_e = 0, st_u = 0, st_i = 0;
  logic [23:0] preset;
  logic [7:0]  psc;
  logic        ld, cclr, fclr, eclr, cen, ipen;
  logic [4:0]  mode, idx;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cnt_host_port dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_ctl_i(bus_ctl),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cnt_value_i(cnt_value),
    .st_borrow_i(st_b), .st_carry_i(st_c), .st_compare_i(st_cmp), .st_sign_i(st_s),
    .st_error_i(st_e), .st_up_i(st_u), .st_index_i(st_i),
    .preset_o(preset), .prescaler_o(psc), .cnt_load_o(ld), .cnt_clear_o(cclr),
    .flags_clear_o(fclr), .error_clear_o(eclr), .mode_cfg_o(mode), .cnt_en_o(cen),
    .idx_preset_en_o(ipen), .irq_sel_o(irq), .idx_cfg_o(idx)
  );

  // behavioural reference model
  int          m_ptr;
  logic [23:0] m_preset, m_latch;
  logic [7:0]  m_psc, m_rdata;
  logic [4:0]  m_mode, m_ioc, m_idx;
  logic        m_ld, m_cclr, m_fclr, m_eclr;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_preset = 0; m_latch = 0; m_psc = 0; m_rdata = 0;
      m_mode = 0; m_ioc = 5'b00010; m_idx = 0;
      m_ld = 0; m_cclr = 0; m_fclr = 0; m_eclr = 0;
    end else begin
      m_ld = 0; m_cclr = 0; m_fclr = 0; m_eclr = 0;
      if (bus_wr) begin
        if (bus_ctl) begin
          if (bus_wdata[7:5] == 3'd0) begin
            if (bus_wdata[0]) m_ptr = 0;
            if (bus_wdata[2:1] == 2'd1) m_cclr = 1;
            if (bus_wdata[2:1] == 2'd2) m_fclr = 1;
            if (bus_wdata[2:1] == 2'd3) m_eclr = 1;
            if (bus_wdata[4:3] == 2'd1) m_ld = 1;
            if (bus_wdata[4:3] == 2'd2) m_latch = cnt_value;
            if (bus_wdata[4:3] == 2'd3) m_psc = m_preset[7:0];
          end else if (bus_wdata[7:5] == 3'd1) m_mode = bus_wdata[4:0];
          else if (bus_wdata[7:5] == 3'd2) m_ioc = bus_wdata[4:0];
          else if (bus_wdata[7:5] == 3'd3) m_idx = bus_wdata[4:0];
        end else begin
          m_preset[m_ptr*8 +: 8] = bus_wdata;
          m_ptr = (m_ptr + 1) % 3;
        end
      end else if (bus_rd) begin
        if (bus_ctl) m_rdata = {1'b0, st_i, st_u, st_e, st_s, st_cmp, st_c, st_b};
        else begin
          m_rdata = m_latch[m_ptr*8 +: 8];
          m_ptr = (m_ptr + 1) % 3;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R11 rdata vs model", 32'(bus_rdata), 32'(m_rdata));
      chk("R4 preset vs model", 32'(preset), 32'(m_preset));
      chk("R9 prescaler vs model", 32'(psc), 32'(m_psc));
      chk("R7 load strobe vs model", 32'(ld), 32'(m_ld));
      chk("R6 strobes vs model", 32'({cclr, fclr, eclr}), 32'({m_cclr, m_fclr, m_eclr}));
      chk("R2 mode/index vs model", 32'({mode, idx}), 32'({m_mode, m_idx}));
      chk("R3 ioctl vs model", 32'({irq, ipen, cen}),
          32'({m_ioc[4:3], ~m_ioc[1], m_ioc[0]}));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // all ops start and end at a falling edge
  task automatic op(input logic w, input logic r, input logic c, input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_ctl = c; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_ctl = 0; bus_wdata = 8'h00;
  endtask

  task automatic cmd(input logic [7:0] d);   op(1, 0, 1, d); endtask
  task automatic dwr(input logic [7:0] d);   op(1, 0, 0, d); endtask
  task automatic drd();                      op(0, 1, 0, 8'h00); endtask
  task automatic srd();                      op(0, 1, 1, 8'h00); endtask
  task automatic idle();                     @(negedge clk); endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    idle();
    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 preset", 32'(preset), 0);
    chk("R1 prescaler", 32'(psc), 0);
    chk("R1 strobes", 32'({ld, cclr, fclr, eclr}), 0);
    chk("R1 cfg", 32'({mode, idx, irq, cen, ipen}), 0);

    // R4 byte order and wrap
    dwr(8'h12); dwr(8'h34); dwr(8'h56);
    chk("R4 preset after three bytes", 32'(preset), 32'h563412);
    dwr(8'hAB);
    chk("R4 fourth byte wraps to byte 0", 32'(preset), 32'h5634AB);

    // R5 pointer reset
    cmd(8'h01); dwr(8'h77);
    chk("R5 write after pointer reset", 32'(preset), 32'h563477);

    // R7 load strobe
    cmd(8'h08);
    chk("R7 load strobe high", 32'(ld), 1);
    chk("R7 preset held", 32'(preset), 32'h563477);
    idle();
    chk("R7 load strobe one cycle", 32'(ld), 0);

    // R6 clear field decoded as a whole
    cmd(8'h02);
    chk("R6 code 01 count clear", 32'({cclr, fclr, eclr}), 32'b100);
    cmd(8'h04);
    chk("R6 code 10 flag clear", 32'({cclr, fclr, eclr}), 32'b010);
    cmd(8'h06);
    chk("R6 code 11 error clear only", 32'({cclr, fclr, eclr}), 32'b001);
    idle();
    chk("R6 strobes drop", 32'({cclr, fclr, eclr}), 0);

    // R8 latch snapshot and held value
    cnt_value = 24'hA1B2C3;
    cmd(8'h11);
    cnt_value = 24'h000001;
    drd(); chk("R8 latch byte 0", 32'(bus_rdata), 32'hC3);
    drd(); chk("R8 latch byte 1", 32'(bus_rdata), 32'hB2);
    drd(); chk("R8 latch byte 2", 32'(bus_rdata), 32'hA1);
    drd(); chk("R8 read wraps to byte 0", 32'(bus_rdata), 32'hC3);

    // R9 prescaler load with pointer reset
    cmd(8'h19);
    chk("R9 prescaler from low preset byte", 32'(psc), 32'h77);
    dwr(8'h99);
    chk("R9 combined code reset pointer", 32'(preset), 32'h563499);

    // R2 and R3 configuration targets
    cmd(8'h35);
    chk("R2 mode register", 32'(mode), 32'h15);
    cmd(8'h6A);
    chk("R2 index register", 32'(idx), 32'h0A);
    cmd(8'h59);
    chk("R3 ioctl 0x19 decode", 32'({cen, ipen, irq}), 32'b1111);
    cmd(8'h4A);
    chk("R3 ioctl 0x0A decode", 32'({cen, ipen, irq}), 32'b0001);

    // R2 ignored targets
    cmd(8'hE5); cmd(8'hA0); cmd(8'hC8);
    chk("R2 ignored: mode/index", 32'({mode, idx}), 32'({5'h15, 5'h0A}));
    chk("R2 ignored: ioctl", 32'({cen, ipen, irq}), 32'b0001);
    chk("R2 ignored: prescaler", 32'(psc), 32'h77);
    dwr(8'h55);
    chk("R2 ignored: pointer unmoved", 32'(preset), 32'h565599);

    // R10 status read
    st_b = 1; st_c = 0; st_cmp = 1; st_s = 0; st_e = 1; st_u = 1; st_i = 0;
    srd();
    chk("R10 status byte", 32'(bus_rdata), 32'h35);
    st_b = 0; st_e = 0; st_i = 1;
    drd();
    chk("R10 status read left pointer at byte 2", 32'(bus_rdata), 32'hA1);

    // R11 hold
    idle(); idle();
    chk("R11 read data holds", 32'(bus_rdata), 32'hA1);
    op(1, 1, 0, 8'h3C);
    chk("R11 write wins over read", 32'(bus_rdata), 32'hA1);
    chk("R11 write served", 32'(preset), 32'h56553C);
    drd();
    chk("R8 latch still held", 32'(bus_rdata), 32'hB2);

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int k;
      logic [7:0] d;
      k = int'($urandom % 10);
      d = 8'($urandom);
      cnt_value = 24'($urandom);
      {st_b, st_c, st_cmp, st_s, st_e, st_u, st_i} = 7'($urandom);
      case (k)
        0, 1, 2: dwr(d);
        3, 4:    drd();
        5:       srd();
        6:       cmd({3'b000, d[4:0]});
        7:       cmd(d);
        8:       op(1, 1, d[7], d);
        default: idle();
      endcase
    end
    idle();
    finish_run();
  end

endmodule